// File: doc/BRIEF.md
# Local Bus FIFO Transfer Engine

This block moves a programmed byte count between a 512-byte internal FIFO and a simple external local bus. A processor programs a packet size, a starting bus address, a chip-select number and a direction through a 32-bit register port. It then fires a start command. The engine issues one 32-bit bus beat per ready handshake. It advances the bus address by four after each beat and counts the bytes moved. When the count reaches the packet size it raises a sticky completion flag.

In the bus-write direction, software or a DMA agent fills the FIFO through the data port and the engine drains it onto the bus. In the bus-read direction, the engine fills the FIFO from the bus and software drains it. A DMA request line follows a programmable alarm level. One interrupt line combines the completion and abort flags with their unmask bits and the master enable. A full FIFO never raises an interrupt.

Top module: `lbus_fifo_engine`

## Requirements
- R1: After reset, the alarm register (offset 0x4C) reads 0x1FF. The enable register (0x0C) and the status register (0x14) read 0. The FIFO status register (0x44) reads 0x00010000, which means empty. `irq` and `dma_req` are low.
- R2: The packet size is held in bits 23:0 of offset 0x00 and is written through byte lanes 0 to 2. A write to offset 0x00 with `reg_be[3]` set and `wdata[24]`=1 is a start command. While a transfer runs, bit 24 of offset 0x00 reads 1.
- R3: Each bus beat moves one 32-bit word. The first beat goes to the start address (offset 0x04), and each later beat goes four bytes higher. `lb_cs` equals control bits 31:24 (offset 0x08). `lb_wr` is 1 when control bit 16 is 0, which means FIFO to bus; in that case `lb_wdata` carries FIFO words in push order. A transfer of S bytes takes ceil(S/4) beats.
- R4: Status bits 23:0 count the bytes transferred; the last beat adds only the bytes that remain. When the count reaches the packet size, status bit 24 (complete) is set and the busy bit clears.
- R5: The status flags are sticky. Writing 1 to bit 24 or bit 28 of offset 0x14 (byte lane 3) clears that flag. Writing 0 to either bit leaves the flag unchanged.
- R6: A start with a packet size of 0, or a start while enable bit 0 (master enable) is 0, sets status bit 28 (abort). No bus beat occurs and the byte count reads 0.
- R7: `irq` = enable bit 0 AND ((complete AND enable bit 8) OR (abort AND enable bit 9)). A full FIFO alone never raises `irq`.
- R8: `dma_req` requires master enable. With control bit 16 = 0, it is high when the FIFO's free bytes are at or above the alarm level. With control bit 16 = 1, it is high when the FIFO's filled bytes are at or above the alarm level.
- R9: A write to offset 0x40 pushes a word and a read from 0x40 pops one, in order. A push into a full FIFO is dropped. Offset 0x44 reports the word count in bits 15:0, empty in bit 16 and full in bit 17.
- R10: An enable write with bit 16 set (lane 2) empties the FIFO. An enable write with bit 24 set (lane 3) stops a running transfer and clears both flags and the byte count.
- R11: A start command issued while a transfer runs is ignored. The running transfer keeps its original size, address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 7 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at 0x40) |
| reg_be | input | 4 | Byte lane enables, bit 3 = bits 31:24 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request from alarm level |
| lb_cs | output | 8 | Chip-select number of the running transfer |
| lb_addr | output | 32 | Bus beat address |
| lb_req | output | 1 | Bus beat request |
| lb_wr | output | 1 | 1 = write to bus, 0 = read from bus |
| lb_wdata | output | 32 | Data to the bus |
| lb_rdata | input | 32 | Data from the bus |
| lb_ack | input | 1 | Ready: the beat completes this cycle |

## Verification
The bench drives packet sizes that are not multiples of four. A design that counted a whole word on the last beat would report too many bytes done or issue an extra beat. It issues a start while a transfer is stalled on an empty FIFO. A design that relatched the new size would finish at the wrong count. It starts with a zero size and with master enable off. A design that ran anyway would show bus beats, and a design that cleared the wrong flag would miss the abort status. The bench also fills the FIFO past capacity and expects the dropped push to leave the first word intact and `irq` low. It exercises both alarm directions, so a swapped occupancy comparison shows up on `dma_req`.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  typedef enum logic [0:0] {ENG_IDLE, ENG_RUN} eng_state_t;

  localparam logic [6:0] OFS_SIZE  = 7'h00;
  localparam logic [6:0] OFS_ADDR  = 7'h04;
  localparam logic [6:0] OFS_CTRL  = 7'h08;
  localparam logic [6:0] OFS_EN    = 7'h0C;
  localparam logic [6:0] OFS_STAT  = 7'h14;
  localparam logic [6:0] OFS_DATA  = 7'h40;
  localparam logic [6:0] OFS_FSTAT = 7'h44;
  localparam logic [6:0] OFS_FCTL  = 7'h48;
  localparam logic [6:0] OFS_ALARM = 7'h4C;

  // bytes carried by the next beat given the bytes still to move
  function automatic logic [31:0] lbf_step(input logic [31:0] left);
    return (left >= 32'd4) ? 32'd4 : left;
  endfunction

  // byte-lane merge, lane 3 = bits 31:24
  function automatic logic [31:0] lbf_merge(input logic [31:0] cur, input logic [31:0] nw,
                                            input logic [3:0] be);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // alarm comparison: filled bytes when reading the bus, free bytes when writing it
  function automatic logic lbf_dma_want(input logic rd, input logic [15:0] occ,
                                        input logic [15:0] cap, input logic [15:0] thr);
    logic [15:0] free_b;
    free_b = cap - occ;
    return rd ? (occ >= thr) : (free_b >= thr);
  endfunction
endpackage

// File: rtl/lbf_fifo.sv
module lbf_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];
  assign count   = cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else if (flush) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == $past(count)));
  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/lbf_xfer.sv
module lbf_xfer import lbf_pkg::*; #(
  parameter int unsigned SIZE_W = 24,
  parameter int unsigned AW     = 32,
  parameter int unsigned CSW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              arm,
  input  logic              arm_ok,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [AW-1:0]     addr_in,
  input  logic [CSW-1:0]    cs_in,
  input  logic              rd_in,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              lb_ack,
  output logic              busy,
  output logic              lb_req,
  output logic [AW-1:0]     lb_addr,
  output logic [CSW-1:0]    lb_cs,
  output logic              rd_dir,
  output logic              beat,
  output logic              fin,
  output logic [SIZE_W-1:0] bytes_done
);
  eng_state_t        st;
  logic [SIZE_W-1:0] left, done_cnt, size_q, step_w;
  logic [AW-1:0]     addr_q;
  logic [CSW-1:0]    cs_q;
  logic              rd_q;

  assign step_w     = SIZE_W'(lbf_step(32'(left)));
  assign busy       = (st == ENG_RUN);
  assign lb_req     = busy && (left != '0) && (rd_q ? !fifo_full : !fifo_empty);
  assign beat       = lb_req && lb_ack;
  assign fin        = beat && (left == step_w);
  assign lb_addr    = addr_q;
  assign lb_cs      = cs_q;
  assign rd_dir     = rd_q;
  assign bytes_done = done_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; left <= '0; done_cnt <= '0; size_q <= '0;
      addr_q <= '0; cs_q <= '0; rd_q <= 1'b0;
    end else if (kill) begin
      st <= ENG_IDLE; left <= '0; done_cnt <= '0;
    end else if (arm) begin
      done_cnt <= '0;
      if (arm_ok) begin
        st <= ENG_RUN; left <= size_in; size_q <= size_in;
        addr_q <= addr_in; cs_q <= cs_in; rd_q <= rd_in;
      end
    end else if (beat) begin
      left     <= left - step_w;
      done_cnt <= done_cnt + step_w;
      addr_q   <= addr_q + AW'(4);
      if (fin) st <= ENG_IDLE;
    end
  end

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_req && !lb_ack) |=> $stable(lb_addr));
  assert_count_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (done_cnt + left == size_q));
  assert_fin_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !kill) |=> !busy);
endmodule

// File: rtl/lbus_fifo_engine.sv
module lbus_fifo_engine import lbf_pkg::*; #(
  parameter int unsigned FIFO_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        dma_req,
  output logic [7:0]  lb_cs,
  output logic [31:0] lb_addr,
  output logic        lb_req,
  output logic        lb_wr,
  output logic [31:0] lb_wdata,
  input  logic [31:0] lb_rdata,
  input  logic        lb_ack
);
  localparam int unsigned FIFO_WORDS = FIFO_BYTES / 4;
  localparam int unsigned FC_W       = $clog2(FIFO_WORDS + 1);
  localparam int unsigned AL_W       = $clog2(FIFO_BYTES);
  localparam int unsigned SIZE_W     = 24;

  logic [SIZE_W-1:0] size_q, size_nx, bytes_done;
  logic [31:0]       saddr_q, fifo_head;
  logic [7:0]        cs_q, fctl_q;
  logic              rd_cfg_q, en_q, en_done_q, en_err_q, done_q, abort_q;
  logic [AL_W-1:0]   alarm_q;
  logic [FC_W-1:0]   fifo_cnt;
  logic              fifo_full, fifo_empty;

  // named internal events
  logic wr_size, wr_addr, wr_ctrl, wr_en, wr_stat, wr_data, wr_fctl, wr_alarm, rd_data;
  logic start_cmd, arm, arm_ok, kill, flush, clr_done, clr_abort;
  logic busy, eng_rd, beat, fin, bus_push, bus_pop, cpu_push, cpu_pop;

  assign wr_size  = reg_wr && (reg_addr == OFS_SIZE);
  assign wr_addr  = reg_wr && (reg_addr == OFS_ADDR);
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_en    = reg_wr && (reg_addr == OFS_EN);
  assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
  assign wr_data  = reg_wr && (reg_addr == OFS_DATA);
  assign wr_fctl  = reg_wr && (reg_addr == OFS_FCTL);
  assign wr_alarm = reg_wr && (reg_addr == OFS_ALARM);
  assign rd_data  = reg_rd && (reg_addr == OFS_DATA);

  assign size_nx   = SIZE_W'(lbf_merge({8'h00, size_q}, reg_wdata, reg_be));
  assign start_cmd = wr_size && reg_be[3] && reg_wdata[24];
  assign arm       = start_cmd && !busy;
  assign arm_ok    = arm && en_q && (size_nx != '0);
  assign kill      = wr_en && reg_be[3] && reg_wdata[24];
  assign flush     = wr_en && reg_be[2] && reg_wdata[16];
  assign clr_done  = wr_stat && reg_be[3] && reg_wdata[24];
  assign clr_abort = wr_stat && reg_be[3] && reg_wdata[28];

  // one push source and one pop source per direction
  assign bus_push = beat && eng_rd;
  assign bus_pop  = beat && !eng_rd;
  assign cpu_push = wr_data && !(busy && eng_rd);
  assign cpu_pop  = rd_data && !(busy && !eng_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0; saddr_q <= '0; cs_q <= '0; rd_cfg_q <= 1'b0;
      en_q <= 1'b0; en_done_q <= 1'b0; en_err_q <= 1'b0;
      done_q <= 1'b0; abort_q <= 1'b0; fctl_q <= '0; alarm_q <= '1;
    end else begin
      if (wr_size) size_q <= size_nx;
      if (wr_addr) saddr_q <= lbf_merge(saddr_q, reg_wdata, reg_be);
      if (wr_ctrl) begin
        if (reg_be[3]) cs_q     <= reg_wdata[31:24];
        if (reg_be[2]) rd_cfg_q <= reg_wdata[16];
      end
      if (wr_en) begin
        if (reg_be[0]) en_q <= reg_wdata[0];
        if (reg_be[1]) begin
          en_done_q <= reg_wdata[8];
          en_err_q  <= reg_wdata[9];
        end
      end
      if (wr_fctl && reg_be[0]) fctl_q <= reg_wdata[7:0];
      if (wr_alarm) alarm_q <= AL_W'(lbf_merge(32'(alarm_q), reg_wdata, reg_be));
      if (kill) begin
        done_q <= 1'b0; abort_q <= 1'b0;
      end else begin
        if (fin) done_q <= 1'b1;
        else if (clr_done) done_q <= 1'b0;
        if (arm && !arm_ok) abort_q <= 1'b1;
        else if (clr_abort) abort_q <= 1'b0;
      end
    end
  end

  lbf_fifo #(.DEPTH(FIFO_WORDS), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(bus_push || cpu_push), .push_data(bus_push ? lb_rdata : reg_wdata),
    .pop(bus_pop || cpu_pop), .head(fifo_head), .count(fifo_cnt),
    .full(fifo_full), .empty(fifo_empty)
  );

  lbf_xfer #(.SIZE_W(SIZE_W), .AW(32), .CSW(8)) u_xfer (
    .clk(clk), .rst_n(rst_n), .kill(kill), .arm(arm), .arm_ok(arm_ok),
    .size_in(size_nx), .addr_in(saddr_q), .cs_in(cs_q), .rd_in(rd_cfg_q),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .lb_ack(lb_ack),
    .busy(busy), .lb_req(lb_req), .lb_addr(lb_addr), .lb_cs(lb_cs),
    .rd_dir(eng_rd), .beat(beat), .fin(fin), .bytes_done(bytes_done)
  );

  assign lb_wr    = !eng_rd;
  assign lb_wdata = fifo_head;
  assign irq      = en_q && ((done_q && en_done_q) || (abort_q && en_err_q));
  assign dma_req  = en_q && lbf_dma_want(rd_cfg_q, 16'({fifo_cnt, 2'b00}),
                                         16'(FIFO_BYTES), 16'(alarm_q));

  always_comb begin
    case (reg_addr)
      OFS_SIZE:  reg_rdata = {7'd0, busy, size_q};
      OFS_ADDR:  reg_rdata = saddr_q;
      OFS_CTRL:  reg_rdata = {cs_q, 7'd0, rd_cfg_q, 16'd0};
      OFS_EN:    reg_rdata = {22'd0, en_err_q, en_done_q, 7'd0, en_q};
      OFS_STAT:  reg_rdata = {3'd0, abort_q, 3'd0, done_q, bytes_done};
      OFS_DATA:  reg_rdata = fifo_head;
      OFS_FSTAT: reg_rdata = {14'd0, fifo_full, fifo_empty, 16'(fifo_cnt)};
      OFS_FCTL:  reg_rdata = {24'd0, fctl_q};
      OFS_ALARM: reg_rdata = 32'(alarm_q);
      default:   reg_rdata = 32'd0;
    endcase
  end

  assert_abort_noreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !arm_ok) |=> (abort_q && !lb_req));
  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done && !kill) |=> done_q);
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && busy && !beat) |=> $stable(lb_addr));
  assert_kill_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!lb_req && !done_q && !abort_q));
endmodule

// File: tb/lbus_fifo_engine_test.sv
`timescale 1ns/1ps
module lbus_fifo_engine_test;
  import lbf_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        wr_s = 1'b0, rd_s = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, dma_req, lb_req, lb_wr, lb_ack = 1'b0;
  logic [7:0]  lb_cs;
  logic [31:0] lb_addr, lb_wdata, lb_rdata = '0;

  int checks = 0, errors = 0;
  int nb = 0;
  logic [31:0] b_addr [64];
  logic [31:0] b_data [64];
  logic        b_wr   [64];
  logic [7:0]  b_cs   [64];

  always #2 clk = ~clk;

  lbus_fifo_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(wr_s), .reg_rd(rd_s),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .dma_req(dma_req), .lb_cs(lb_cs), .lb_addr(lb_addr), .lb_req(lb_req),
    .lb_wr(lb_wr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction
  function automatic int beats_for(input int sz);
    return (sz + 3) / 4;
  endfunction
  function automatic logic [31:0] stat_word(input logic dn, input logic ab, input int cnt);
    return {3'd0, ab, 3'd0, dn, 24'(cnt)};
  endfunction

  // bus responder: decides the ack at the falling edge, records the beat it completes
  initial begin
    forever begin
      @(negedge clk);
      lb_ack = 1'b0;
      if (lb_req && ($urandom % 3 != 0)) begin
        lb_ack   = 1'b1;
        lb_rdata = pat(lb_addr);
        if (nb < 64) begin
          b_addr[nb] = lb_addr; b_data[nb] = lb_wdata;
          b_wr[nb] = lb_wr; b_cs[nb] = lb_cs;
        end
        nb++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_addr = a; reg_wdata = d; reg_be = be; wr_s = 1'b1;
    @(negedge clk);
    wr_s = 1'b0; reg_be = '0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a; rd_s = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    rd_s = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(OFS_SIZE, v);
      if (!v[24]) break;
    end
  endtask

  task automatic start(input int sz);
    wr_reg(OFS_SIZE, 32'(sz), 4'b0111);
    wr_reg(OFS_SIZE, 32'h0100_0000, 4'b1000);
  endtask

  task automatic flush();
    wr_reg(OFS_EN, 32'h0001_0000, 4'b0100);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, base;
    logic [31:0] w [8];
    int n, sz, exp_n;
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(OFS_ALARM, v); chk("R1 alarm", v, 32'h1FF);
    rd_reg(OFS_EN, v);    chk("R1 enable", v, 32'h0);
    rd_reg(OFS_STAT, v);  chk("R1 status", v, 32'h0);
    rd_reg(OFS_FSTAT, v); chk("R1 fifo status", v, 32'h0001_0000);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 dma_req", 32'(dma_req), 32'h0);

    // R8 write direction: free bytes against alarm 0x1FF
    wr_reg(OFS_EN, 32'h0000_0301, 4'b0011);
    wr_reg(OFS_CTRL, 32'h0500_0000, 4'b1111);
    chk("R8 empty fifo, write dir", 32'(dma_req), 32'h1);
    wr_reg(OFS_DATA, 32'hDEAD_BEEF, 4'b1111);
    chk("R8 one word, free 508", 32'(dma_req), 32'h0);
    flush();

    // R2 R3 R4 R5 R7 FIFO to bus, partial last word
    for (int it = 0; it < 4; it++) begin
      flush();
      nb = 0;
      n = 1 + ($urandom % 6);
      for (int k = 0; k < n; k++) begin
        w[k] = $urandom;
        wr_reg(OFS_DATA, w[k], 4'b1111);
      end
      sz = 4 * (n - 1) + 1 + ($urandom % 4);
      base = $urandom & 32'hFFFF_FFFC;
      wr_reg(OFS_ADDR, base, 4'b1111);
      start(sz);
      rd_reg(OFS_SIZE, v);
      chk("R2 busy after start", 32'(v[24] | (nb > 0 && !v[24] ? 1'b1 : 1'b0)), 32'h1);
      wait_idle();
      chk("R3 beat count write", 32'(nb), 32'(beats_for(sz)));
      for (int k = 0; k < n && k < nb; k++) begin
        chk("R3 beat addr", b_addr[k], base + 32'(4 * k));
        chk("R3 beat data", b_data[k], w[k]);
        chk("R3 beat dir/cs", {23'd0, b_wr[k], b_cs[k]}, {23'd0, 1'b1, 8'h05});
      end
      rd_reg(OFS_STAT, v); chk("R4 status after write", v, stat_word(1'b1, 1'b0, sz));
      chk("R7 completion irq", 32'(irq), 32'h1);
      wr_reg(OFS_STAT, 32'h0, 4'b1111);
      rd_reg(OFS_STAT, v); chk("R5 zero write keeps flag", v, stat_word(1'b1, 1'b0, sz));
      wr_reg(OFS_STAT, 32'h0100_0000, 4'b1000);
      rd_reg(OFS_STAT, v); chk("R5 W1C complete", v, stat_word(1'b0, 1'b0, sz));
      chk("R7 irq after clear", 32'(irq), 32'h0);
    end

    // R3 R4 R8 bus to FIFO
    wr_reg(OFS_CTRL, 32'h0301_0000, 4'b1111);
    wr_reg(OFS_ALARM, 32'd8, 4'b0011);
    for (int it = 0; it < 3; it++) begin
      flush();
      nb = 0;
      sz = 1 + ($urandom % 20);
      base = $urandom & 32'hFFFF_FFFC;
      wr_reg(OFS_ADDR, base, 4'b1111);
      start(sz);
      wait_idle();
      exp_n = beats_for(sz);
      chk("R3 beat count read", 32'(nb), 32'(exp_n));
      chk("R3 read dir/cs", {23'd0, b_wr[0], b_cs[0]}, {23'd0, 1'b0, 8'h03});
      rd_reg(OFS_STAT, v); chk("R4 status after read", v, stat_word(1'b1, 1'b0, sz));
      rd_reg(OFS_FSTAT, v); chk("R9 fifo count after read", v, 32'(exp_n));
      chk("R8 filled vs alarm", 32'(dma_req), 32'(exp_n * 4 >= 8));
      for (int k = 0; k < exp_n; k++) begin
        rd_reg(OFS_DATA, v); chk("R3 read data order", v, pat(base + 32'(4 * k)));
      end
      chk("R8 drained fifo", 32'(dma_req), 32'h0);
      wr_reg(OFS_STAT, 32'h0100_0000, 4'b1000);
    end

    // R6 abort cases
    wr_reg(OFS_CTRL, 32'h0500_0000, 4'b1111);
    flush();
    nb = 0;
    start(0);
    rd_reg(OFS_STAT, v); chk("R6 zero size abort", v, stat_word(1'b0, 1'b1, 0));
    chk("R7 error irq", 32'(irq), 32'h1);
    chk("R6 no beats", 32'(nb), 32'h0);
    wr_reg(OFS_STAT, 32'h1000_0000, 4'b1000);
    rd_reg(OFS_STAT, v); chk("R5 W1C abort", v, 32'h0);
    wr_reg(OFS_EN, 32'h0000_0300, 4'b0011);
    wr_reg(OFS_DATA, 32'h1234_5678, 4'b1111);
    start(8);
    rd_reg(OFS_STAT, v); chk("R6 disabled abort", v, stat_word(1'b0, 1'b1, 0));
    chk("R7 irq gated by master enable", 32'(irq), 32'h0);
    chk("R6 no beats when disabled", 32'(nb), 32'h0);
    wr_reg(OFS_STAT, 32'h1000_0000, 4'b1000);
    wr_reg(OFS_EN, 32'h0000_0301, 4'b0011);

    // R11 second start while stalled
    flush();
    nb = 0;
    start(8);
    wr_reg(OFS_SIZE, 32'h0100_000C, 4'b1111);
    rd_reg(OFS_SIZE, v); chk("R11 still busy, size stored", v, 32'h0100_000C);
    for (int k = 0; k < 3; k++) wr_reg(OFS_DATA, 32'(k + 100), 4'b1111);
    wait_idle();
    chk("R11 original size beats", 32'(nb), 32'h2);
    rd_reg(OFS_STAT, v); chk("R11 original size count", v, stat_word(1'b1, 1'b0, 8));

    // R10 engine stop and FIFO flush
    flush();
    start(8);
    rd_reg(OFS_SIZE, v); chk("R10 busy before stop", 32'(v[24]), 32'h1);
    wr_reg(OFS_EN, 32'h0100_0000, 4'b1000);
    rd_reg(OFS_SIZE, v); chk("R10 idle after stop", v, 32'h0000_0008);
    rd_reg(OFS_STAT, v); chk("R10 flags and count cleared", v, 32'h0);
    chk("R10 no request", 32'(lb_req), 32'h0);
    for (int k = 0; k < 3; k++) wr_reg(OFS_DATA, 32'(k), 4'b1111);
    flush();
    rd_reg(OFS_FSTAT, v); chk("R10 flush empties", v, 32'h0001_0000);

    // R9 overflow, R7 no full interrupt, R8 full fifo
    for (int k = 0; k < 129; k++) wr_reg(OFS_DATA, 32'(k + 32'hA000), 4'b1111);
    rd_reg(OFS_FSTAT, v); chk("R9 full status", v, 32'h0002_0080);
    chk("R7 no irq on full", 32'(irq), 32'h0);
    chk("R8 full fifo write dir", 32'(dma_req), 32'h0);
    rd_reg(OFS_DATA, v); chk("R9 first word kept", v, 32'h0000_A000);
    rd_reg(OFS_DATA, v); chk("R9 second word order", v, 32'h0000_A001);
    rd_reg(OFS_FSTAT, v); chk("R9 count after pops", v, 32'h0000_007E);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule